// File: doc/BRIEF.md
# Run-Length Expanding Byte Stream Decoder

This block sits on the peripheral side of an enhanced parallel link. It takes the forward byte stream after the physical handshake has been recovered. Each byte arrives with a flag that marks it as a command byte or a data byte. A command byte holds one of two things, chosen by its top bit: a 7-bit channel address, or a repeat count stored as the run length minus one.

Address commands update a registered channel-address output and raise a one-cycle strobe. Count commands are held as pending, and the next data byte is then repeated the stored number of times plus one. With no count pending, a data byte passes through once.

The input and output are both valid/ready byte streams. The input is held off while an expansion still has repeats to send, and stalls on the output never drop a repeat.

Top module: `rle_ecp_decoder`

## Requirements
- R1: After reset, out_valid is 0, addr_stb is 0, addr_out is 0 and in_ready is 1.
- R2: An accepted command byte (in_cmd=1) with bit 7 set loads bits 6..0 into addr_out and pulses addr_stb high for the single cycle that follows the acceptance.
- R3: An address command produces no byte on the output stream.
- R4: An accepted command byte with bit 7 clear stores bits 6..0 as a pending count N. The next data byte (in_cmd=0) is then emitted N+1 times, so a count of 1 gives two identical bytes and a count of 0 gives one byte.
- R5: A data byte accepted with no count pending is emitted exactly once.
- R6: The pending count is cleared when a data byte uses it, so the data byte after that is emitted once.
- R7: A second count command accepted before any data byte replaces the pending count.
- R8: in_ready is 0 while the output holds a byte that still has repeats left to send.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data is unchanged, and no repeat is lost.
- R10: A count field of 127 expands the following data byte into 128 output bytes.
- R11: An accepted data byte appears on out_valid/out_data in the cycle after the acceptance, and out_valid only rises after a data byte has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Decoder can accept an input byte |
| in_cmd | input | 1 | 1 = command byte, 0 = data byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| addr_out | output | 7 | Last channel address received |
| addr_stb | output | 1 | One-cycle pulse when addr_out is updated |

## Verification
The bench builds the block with its default byte width of 8, which gives a 7-bit count and address field. At that width the longest run of 128 repeats and the full address range fit within a short test. Output readiness is driven in three modes: always ready, random stalls, and a long hold. The hold mode brings the stalled-expansion and held-input cases within reach alongside count replacement and address updates placed between runs.

// File: rtl/rle_pkg.sv
package rle_pkg;
   typedef enum logic [1:0] {
      BK_NONE = 2'd0,
      BK_DATA = 2'd1,
      BK_ADDR = 2'd2,
      BK_CNT  = 2'd3
   } byte_kind_e;
endpackage

// File: rtl/rle_cmd_decode.sv
module rle_cmd_decode
   import rle_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int FLD_W = DATA_W - 1
) (
   input  logic              fire,
   input  logic              is_cmd,
   input  logic [DATA_W-1:0] byte_in,
   output byte_kind_e        kind,
   output logic [FLD_W-1:0]  field
);
   always_comb begin
      field = byte_in[FLD_W-1:0];
      if (!fire)                  kind = BK_NONE;
      else if (!is_cmd)           kind = BK_DATA;
      else if (byte_in[DATA_W-1]) kind = BK_ADDR;
      else                        kind = BK_CNT;
   end
endmodule

// File: rtl/rle_addr_reg.sv
module rle_addr_reg #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic              stb_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         stb_q  <= 1'b0;
      end else begin
         stb_q <= load;
         if (load) addr_q <= addr_in;
      end
   end
endmodule

// File: rtl/rle_expander.sv
module rle_expander #(
   parameter int DATA_W = 8,
   localparam int CNT_W = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_data,
   input  logic              take_cnt,
   input  logic [DATA_W-1:0] data_in,
   input  logic [CNT_W-1:0]  cnt_in,
   output logic              can_take,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   logic [CNT_W-1:0] rem_q;
   logic [CNT_W-1:0] pend_q;
   logic             pend_v;
   logic             out_fire;
   logic             last_rep;

   assign out_fire = out_valid && out_ready;
   assign last_rep = (rem_q == '0);
   assign can_take = !out_valid || (out_ready && last_rep);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         rem_q     <= '0;
         pend_q    <= '0;
         pend_v    <= 1'b0;
      end else begin
         if (take_cnt) begin
            pend_q <= cnt_in;
            pend_v <= 1'b1;
         end
         if (take_data) begin
            out_valid <= 1'b1;
            out_data  <= data_in;
            rem_q     <= pend_v ? pend_q : '0;
            pend_v    <= 1'b0;
            pend_q    <= '0;
         end else if (out_fire) begin
            if (last_rep) out_valid <= 1'b0;
            else          rem_q     <= rem_q - 1'b1;
         end
      end
   end

   assert_ready_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !last_rep) |-> !can_take);
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   assert_repeat_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && !last_rep && !take_data) |=> (out_valid && rem_q == $past(rem_q) - 1'b1));
endmodule

// File: rtl/rle_ecp_decoder.sv
module rle_ecp_decoder
   import rle_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int FLD_W = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_cmd,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic [FLD_W-1:0]  addr_out,
   output logic              addr_stb
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("rle_ecp_decoder: DATA_W must be at least 2");
      end
   endgenerate

   byte_kind_e       kind;
   logic [FLD_W-1:0] field;
   logic             in_fire;

   assign in_fire = in_valid && in_ready;

   rle_cmd_decode #(.DATA_W(DATA_W)) u_dec (
      .fire    (in_fire),
      .is_cmd  (in_cmd),
      .byte_in (in_data),
      .kind    (kind),
      .field   (field)
   );

   rle_addr_reg #(.ADDR_W(FLD_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (kind == BK_ADDR),
      .addr_in (field),
      .addr_q  (addr_out),
      .stb_q   (addr_stb)
   );

   rle_expander #(.DATA_W(DATA_W)) u_exp (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_data (kind == BK_DATA),
      .take_cnt  (kind == BK_CNT),
      .data_in   (in_data),
      .cnt_in    (field),
      .can_take  (in_ready),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data)
   );

   assert_stb_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_stb) |-> $past(in_valid && in_ready && in_cmd && in_data[DATA_W-1]));
   assert_stb_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_cmd && in_data[DATA_W-1]) |=>
      (addr_stb && addr_out == $past(in_data[FLD_W-1:0])));
   assert_no_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready && !in_cmd));
   assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_cmd) |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: tb/rle_ecp_decoder_test.sv
module rle_ecp_decoder_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic       in_cmd = 1'b0;
   logic [7:0] in_data = '0;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [7:0] out_data;
   logic [6:0] addr_out;
   logic       addr_stb;

   int checks = 0;
   int errors = 0;
   int ready_mode = 0;
   int pend = -1;
   int cycles = 0;
   logic [7:0] exp_d[$];
   string      exp_t[$];
   logic [6:0] exp_a[$];

   always #10 clk = ~clk;

   rle_ecp_decoder uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_cmd(in_cmd), .in_data(in_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .addr_out(addr_out),
      .addr_stb(addr_stb)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // driver: offers one byte, updates the model when it is accepted
   task automatic send(input bit c, input logic [7:0] d, input string tag);
      bit ok;
      @(negedge clk);
      in_valid = 1'b1; in_cmd = c; in_data = d;
      do begin
         #8;
         ok = in_ready;
         if (ok) begin
            if (c && d[7]) exp_a.push_back(d[6:0]);
            else if (c) pend = int'(d[6:0]);
            else begin
               for (int k = 0; k < ((pend < 0) ? 1 : pend + 1); k++) begin
                  exp_d.push_back(d);
                  exp_t.push_back(tag);
               end
               pend = -1;
            end
         end
         @(negedge clk);
      end while (!ok);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_d.size() != 0 || out_valid) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // out_ready driver
   always @(negedge clk) begin
      case (ready_mode)
         0: out_ready <= 1'b1;
         1: out_ready <= ($urandom_range(0, 2) != 0);
         default: out_ready <= 1'b0;
      endcase
   end

   // monitor: samples shortly before each rising edge
   initial begin
      forever begin
         @(negedge clk); #8;
         if (rst_n && out_valid && out_ready) begin
            if (exp_d.size() == 0) check(1'b0, "R3/R5 unexpected byte", int'(out_data), -1);
            else begin
               logic [7:0] e; string t;
               e = exp_d.pop_front(); t = exp_t.pop_front();
               check(out_data == e, t, int'(out_data), int'(e));
            end
         end
         if (rst_n && addr_stb) begin
            if (exp_a.size() == 0) check(1'b0, "R2 unexpected strobe", int'(addr_out), -1);
            else begin
               logic [6:0] ea;
               ea = exp_a.pop_front();
               check(addr_out == ea, "R2 address value", int'(addr_out), int'(ea));
            end
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         check(1'b0, "watchdog", cycles, 100000);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #5;
      check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
      check(addr_stb == 1'b0, "R1 addr_stb", int'(addr_stb), 0);
      check(addr_out == 7'd0, "R1 addr_out", int'(addr_out), 0);
      check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

      // R5 plain data, R11 latency asserted in RTL
      send(1'b0, 8'hA5, "R5 single");
      send(1'b0, 8'h3C, "R5 single");
      // R2/R3 address commands between data
      send(1'b1, 8'h80 | 8'h15, "R2");
      send(1'b1, 8'hFF, "R2");
      send(1'b0, 8'h11, "R3 no emit");
      // R4 count 1 -> two bytes, count 0 -> one byte
      send(1'b1, 8'h01, "R4");
      send(1'b0, 8'h77, "R4 count1");
      send(1'b1, 8'h00, "R4");
      send(1'b0, 8'h66, "R4 count0");
      // R6 count cleared after use
      send(1'b1, 8'h04, "R6");
      send(1'b0, 8'h21, "R6 used");
      send(1'b0, 8'h22, "R6 cleared");
      // R7 replacement
      send(1'b1, 8'h09, "R7");
      send(1'b1, 8'h02, "R7");
      send(1'b0, 8'h5A, "R7 replaced");
      drain();

      // R8/R9 stall during expansion
      ready_mode = 2;
      send(1'b1, 8'h03, "R9");
      send(1'b0, 8'hC3, "R9 stalled run");
      repeat (4) @(negedge clk);
      #4;
      check(out_valid == 1'b1, "R9 out_valid held", int'(out_valid), 1);
      check(out_data == 8'hC3, "R9 out_data held", int'(out_data), 'hC3);
      check(in_ready == 1'b0, "R8 in_ready low", int'(in_ready), 0);
      ready_mode = 0;
      drain();

      // R10 maximum run, random backpressure
      ready_mode = 1;
      send(1'b1, 8'h7F, "R10");
      send(1'b0, 8'hE1, "R10 run128");
      send(1'b1, 8'h85, "R2");
      send(1'b1, 8'h05, "R9");
      send(1'b0, 8'h0F, "R9 random stall");
      for (int i = 0; i < 6; i++) send(1'b0, 8'(i * 17), "R5 burst");
      drain();
      ready_mode = 0;

      check(exp_d.size() == 0, "R4 all repeats seen", exp_d.size(), 0);
      check(exp_a.size() == 0, "R2 all strobes seen", exp_a.size(), 0);
      check(addr_out == 7'h05, "R2 final address", int'(addr_out), 5);
      finish_run();
   end
endmodule